// File: doc/BRIEF.md
# SCL Stretch Watchdog and Interrupt Status Unit

This unit sits beside an I2C master and watches the two bus lines. It counts how long SCL stays low, measured in SCL periods supplied as a tick input. When the low phase lasts longer than a programmed window, it raises a timeout event. It also presents the present SDA and SCL levels as a two-bit word.

The master's transfer-done pulse and the timeout event are collected into a raw status word. A per-source enable mask turns that word into a masked status word. A single interrupt line is the OR of the masked bits. Software acknowledges a source by writing a one to that source's bit in the clear input.

The programmed window is an 8-bit value that fills the top of a 12-bit counter; the bottom four counter bits always load as zero. A window value of 0x7D therefore covers 2000 SCL periods, which is 20 ms at 100 kHz.

Top module: `i2c_lowclk_monitor`

## Requirements
- R1: `line_state` equals {`sda_in`, `scl_in`} in the same cycle: SDA in bit 1, SCL in bit 0.
- R2: With `tmo_limit` = L (L > 0), the timeout event fires on the clock edge that registers the (L*16)-th `scl_tick` seen while `scl_in` is continuously low. Clock cycles that have no tick do not advance the count.
- R3: Each cycle with `scl_in` high reloads the window. Ticks that arrive while SCL is high never bring a timeout closer.
- R4: Within one low phase the timeout event fires at most once. It can fire again only after `scl_in` has been high for at least one cycle.
- R5: `tmo_limit` = 0 disables the timeout entirely.
- R6: `raw_stat` bit 0 is the done source (`done_evt`) and bit 1 is the timeout source. A bit sets on the clock edge after its event and then holds until it is cleared.
- R7: A cycle with `clr_we` high clears, on that edge, each `raw_stat` bit whose `clr_bits` bit is 1. Bits whose `clr_bits` bit is 0 are unchanged.
- R8: If an event and a clear of the same bit arrive in the same cycle, the bit ends up set.
- R9: `masked_stat` equals `raw_stat` AND `irq_mask`, with no added delay.
- R10: `irq` is the OR of the `masked_stat` bits. A source whose mask bit is 0 never drives `irq`, even though its raw bit still sets.
- R11: After a synchronous reset, `raw_stat` is zero, `irq` is low, and no timeout can fire until `scl_in` has been seen high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Sampled SCL level |
| sda_in | input | 1 | Sampled SDA level |
| scl_tick | input | 1 | One-cycle pulse per SCL period |
| done_evt | input | 1 | One-cycle pulse when the master completes an operation |
| tmo_limit | input | 8 | Timeout window, in units of 16 SCL periods; 0 disables |
| irq_mask | input | 2 | Per-source enable (bit 0 done, bit 1 timeout) |
| clr_we | input | 1 | Strobe for the write-one-to-clear word |
| clr_bits | input | 2 | Bits of `raw_stat` to clear |
| line_state | output | 2 | {SDA, SCL} live levels |
| raw_stat | output | 2 | Unmasked status bits |
| masked_stat | output | 2 | Status bits gated by `irq_mask` |
| irq | output | 1 | Interrupt request |

## Verification
`line_state`, `masked_stat` and `irq` respond to their inputs within the same cycle. `raw_stat` responds one edge after an event or a clear. A timeout is due on the edge that registers the (L*16)-th low tick. The bench drives inputs at the falling edge. Combinational results and status results are both read 2 ns after the next rising edge, while the inputs are still held. For timeout runs, the bench reads status at the falling edge that follows the last tick, so the edge registering the expiry has already passed. Each timeout run is checked one tick before its due point and again exactly at it.

// File: rtl/lcm_pkg.sv
package lcm_pkg;
    // Number of interrupt sources and their bit positions in the status words
    localparam int NSRC     = 2;
    localparam int SRC_DONE = 0;
    localparam int SRC_TMO  = 1;
    // Timeout counter geometry
    localparam int CNT_W = 12;
    localparam int LIM_W = 8;
endpackage

// File: rtl/lcm_low_timer.sv
// Clock-low window counter.
// Loads {limit, zeros} while SCL is high and counts SCL ticks down while SCL
// is low. It emits a one-cycle expiry pulse when the count passes 1 -> 0 and
// then stays at 0 until SCL is high again, so each low phase expires at most once.
// Assumes scl_in is already synchronised and tick is a one-cycle pulse.
module lcm_low_timer #(
    parameter int CNT_W = 12,
    parameter int LIM_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_in,
    input  logic             tick,
    input  logic [LIM_W-1:0] limit,
    output logic             expire
);
    localparam int FRAC_W = CNT_W - LIM_W;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] load_val;

    // Window value: programmable upper bits, fixed-zero lower bits
    assign load_val = {limit, {FRAC_W{1'b0}}};

    // Expiry: the last tick of the window arrives while SCL is low
    assign expire = !scl_in && tick && (cnt == CNT_W'(1));

    // Reload while SCL is high, count down on ticks while SCL is low
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (scl_in) begin
            cnt <= load_val;
        end else if (tick && (cnt != '0)) begin
            cnt <= cnt - CNT_W'(1);
        end
    end

    // R4
    expire_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> !expire);

    // R2
    count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!scl_in && !tick) |=> $stable(cnt));
endmodule

// File: rtl/lcm_irq_status.sv
// Raw interrupt status with write-one-to-clear.
// One sticky bit per source; a set in the same cycle as a clear wins.
// Assumes events are single-cycle pulses in the clk domain.
module lcm_irq_status #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] evt,
    input  logic         clr_we,
    input  logic [N-1:0] clr_bits,
    output logic [N-1:0] raw
);
    for (genvar i = 0; i < N; i++) begin : g_src
        // Sticky flag for source i: event sets, strobed one clears
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                raw[i] <= 1'b0;
            end else if (evt[i]) begin
                raw[i] <= 1'b1;
            end else if (clr_we && clr_bits[i]) begin
                raw[i] <= 1'b0;
            end
        end

        // R8
        set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
            evt[i] |=> raw[i]);

        // R7
        clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_we && clr_bits[i] && !evt[i]) |=> !raw[i]);

        // R6
        hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!evt[i] && !(clr_we && clr_bits[i])) |=> $stable(raw[i]));
    end
endmodule

// File: rtl/i2c_lowclk_monitor.sv
// Top: SCL low-time watchdog plus interrupt status unit.
// Combines the window timer with the status register. The live line word, the
// masked word and the irq line are combinational on the registered status.
// Assumes all inputs are synchronous to clk.
module i2c_lowclk_monitor
    import lcm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_in,
    input  logic             sda_in,
    input  logic             scl_tick,
    input  logic             done_evt,
    input  logic [LIM_W-1:0] tmo_limit,
    input  logic [NSRC-1:0]  irq_mask,
    input  logic             clr_we,
    input  logic [NSRC-1:0]  clr_bits,
    output logic [1:0]       line_state,
    output logic [NSRC-1:0]  raw_stat,
    output logic [NSRC-1:0]  masked_stat,
    output logic             irq
);
    logic            tmo_pulse;
    logic [NSRC-1:0] events;

    lcm_low_timer #(.CNT_W(CNT_W), .LIM_W(LIM_W)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .scl_in (scl_in),
        .tick   (scl_tick),
        .limit  (tmo_limit),
        .expire (tmo_pulse)
    );

    // Event vector in status bit order
    always_comb begin
        events           = '0;
        events[SRC_DONE] = done_evt;
        events[SRC_TMO]  = tmo_pulse;
    end

    lcm_irq_status #(.N(NSRC)) u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt      (events),
        .clr_we   (clr_we),
        .clr_bits (clr_bits),
        .raw      (raw_stat)
    );

    // Live bus levels: SDA high bit, SCL low bit
    assign line_state  = {sda_in, scl_in};
    // Masked view and interrupt line
    assign masked_stat = raw_stat & irq_mask;
    assign irq         = |masked_stat;

    // R10
    quiet_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq |-> (masked_stat == '0));

    // R9
    mask_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (masked_stat & ~irq_mask) == '0);

    // R5
    no_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tmo_limit == '0 && $stable(tmo_limit)) |-> !tmo_pulse);
endmodule

// File: tb/sim_i2c_lowclk_monitor.sv
module sim_i2c_lowclk_monitor;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_in = 1'b1, sda_in = 1'b1, scl_tick = 1'b0, done_evt = 1'b0;
    logic [7:0] tmo_limit = 8'd0;
    logic [1:0] irq_mask = 2'b00, clr_bits = 2'b00;
    logic       clr_we = 1'b0;
    logic [1:0] line_state, raw_stat, masked_stat;
    logic       irq;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;  // 125 MHz

    i2c_lowclk_monitor u0 (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .scl_tick(scl_tick), .done_evt(done_evt), .tmo_limit(tmo_limit),
        .irq_mask(irq_mask), .clr_we(clr_we), .clr_bits(clr_bits),
        .line_state(line_state), .raw_stat(raw_stat),
        .masked_stat(masked_stat), .irq(irq)
    );

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Low-SCL ticks on consecutive cycles; optional idle cycle between ticks
    task automatic low_ticks(input int n, input bit gaps);
        for (int k = 0; k < n; k++) begin
            @(negedge clk); scl_in = 1'b0; scl_tick = 1'b1;
            if (gaps) begin
                @(negedge clk); scl_tick = 1'b0;
            end
        end
        @(negedge clk); scl_tick = 1'b0;
    endtask

    task automatic scl_high_cycle();
        @(negedge clk); scl_in = 1'b1; scl_tick = 1'b0;
        @(negedge clk); scl_in = 1'b0;
    endtask

    task automatic clear_all();
        @(negedge clk); clr_we = 1'b1; clr_bits = 2'b11;
        @(negedge clk); clr_we = 1'b0; clr_bits = 2'b00;
    endtask

    // Vector: scl sda done clr clrb[2] mask[2] | line[2] raw[2] irq
    localparam logic [12:0] VEC [6] = '{
        13'b0_0_1_0_00_00_00_01_0,  // R6 done sets, R10 masked off -> no irq
        13'b1_0_0_0_00_01_01_01_1,  // R9 R10 enable done -> irq
        13'b0_1_0_1_10_01_10_01_1,  // R7 clearing other bit leaves done
        13'b1_1_0_1_01_01_11_00_0,  // R7 W1C of done
        13'b1_1_1_1_01_00_11_01_0,  // R8 set beats clear
        13'b0_0_0_1_11_11_00_00_0   // R7 clear all, R1 line word
    };

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        check("R11 raw", {2'b0, raw_stat}, 4'h0);
        check("R11 irq", {3'b0, irq}, 4'h0);
        @(negedge clk); rst_n = 1'b1;

        // Vector table
        foreach (VEC[i]) begin
            @(negedge clk);
            scl_in = VEC[i][12]; sda_in = VEC[i][11]; done_evt = VEC[i][10];
            clr_we = VEC[i][9]; clr_bits = VEC[i][8:7]; irq_mask = VEC[i][6:5];
            @(posedge clk); #2;
            check("R1 line", {2'b0, line_state}, {2'b0, VEC[i][4:3]});
            check("R6/R7/R8 raw", {2'b0, raw_stat}, {2'b0, VEC[i][2:1]});
            check("R9 masked", {2'b0, masked_stat}, {2'b0, VEC[i][2:1] & VEC[i][6:5]});
            check("R10 irq", {3'b0, irq}, {3'b0, VEC[i][0]});
        end
        @(negedge clk); done_evt = 1'b0; clr_we = 1'b0; clr_bits = 2'b00;

        // R2 window of 16 ticks for limit 1, timeout enabled as irq source
        tmo_limit = 8'd1; irq_mask = 2'b10;
        scl_high_cycle();
        low_ticks(15, 1'b0);
        check("R2 before window", {2'b0, raw_stat}, 4'h0);
        low_ticks(1, 1'b0);
        check("R2 at window", {2'b0, raw_stat}, 4'h2);
        check("R10 timeout irq", {3'b0, irq}, 4'h1);

        // R4 no second timeout in same low phase
        clear_all();
        low_ticks(40, 1'b0);
        check("R4 once per low", {2'b0, raw_stat}, 4'h0);
        // R4 re-arm after SCL high
        scl_high_cycle();
        low_ticks(16, 1'b0);
        check("R4 rearmed", {2'b0, raw_stat}, 4'h2);
        clear_all();

        // R3 ticks while SCL high do nothing
        for (int k = 0; k < 40; k++) begin
            @(negedge clk); scl_in = 1'b1; scl_tick = 1'b1;
        end
        @(negedge clk); scl_tick = 1'b0;
        check("R3 high ticks", {2'b0, raw_stat}, 4'h0);
        // R3 SCL high mid-window reloads
        @(negedge clk); scl_in = 1'b0;
        low_ticks(10, 1'b0);
        scl_high_cycle();
        low_ticks(15, 1'b0);
        check("R3 reload", {2'b0, raw_stat}, 4'h0);
        low_ticks(1, 1'b0);
        check("R3 full after reload", {2'b0, raw_stat}, 4'h2);
        clear_all();

        // R2 upper-bit scaling: limit 2 -> 32 ticks, gaps between ticks
        tmo_limit = 8'd2;
        scl_high_cycle();
        low_ticks(31, 1'b1);
        check("R2 limit2 before", {2'b0, raw_stat}, 4'h0);
        low_ticks(1, 1'b1);
        check("R2 limit2 at", {2'b0, raw_stat}, 4'h2);
        clear_all();

        // R5 limit 0 disables
        tmo_limit = 8'd0;
        scl_high_cycle();
        low_ticks(300, 1'b0);
        check("R5 disabled", {2'b0, raw_stat}, 4'h0);

        // R10 masked-off timeout still sets raw, no irq
        tmo_limit = 8'd1; irq_mask = 2'b01;
        scl_high_cycle();
        low_ticks(16, 1'b0);
        check("R10 raw sets", {2'b0, raw_stat}, 4'h2);
        check("R10 no irq", {3'b0, irq}, 4'h0);

        // R11 reset clears and needs SCL high before counting
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        check("R11 raw after reset", {2'b0, raw_stat}, 4'h0);
        low_ticks(40, 1'b0);
        check("R11 no tmo before high", {2'b0, raw_stat}, 4'h0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule